// File: doc/BRIEF.md
# Top-of-Memory Forwarding Decoder

This block decides whether a host-bus memory request that lies above installed main memory is claimed and passed to the PCI side. Software programs one 32-bit configuration word through a simple write port. The word holds an enable flag and a boundary expressed in 1 MB units. Every host request is registered together with the hit flags from external memory-gap range checkers. One cycle later the block raises a single-cycle claim if all of these hold: the request's 1 MB index is at or above the boundary, it lies below the 64 GB ceiling, no gap checker reported a hit, and forwarding is enabled.

The same boundary guards the opposite direction. While forwarding is enabled, a PCI-initiated memory request that falls in the claimed window produces a single-cycle block pulse, so that the access is kept off the host bus. A request that falls inside a gap hole is not blocked. The gap registers, the bus protocol timing and the main memory controller live outside this block.

Top module: `tom_fwd_decoder`

## Requirements
- R1: After reset, the configuration word reads 0x0000_0000, and both `host_claim` and `pci_block` are low.
- R2: A write keeps only bit 31 (enable) and bits 15:0 (boundary), so a write of 0xFFFF_FFFF reads back as 0x8000_FFFF. Bits 30:16 always read as zero.
- R3: A request is presented with `host_req_valid` high in cycle N. It has bit 31 set, address bits 35:20 at or above the boundary, and no gap hit. Then `host_claim` is high in cycle N+1.
- R4: The boundary counts 1 MB units on address bits 35:20. With a boundary of B, the address B×2^20 is claimed and the address B×2^20−1 is not. A boundary of 1 therefore starts at 0x0010_0000.
- R5: While bit 31 is clear, `host_claim` and `pci_block` both stay low, whatever the address.
- R6: A request whose `host_gap_hit` vector has any bit set is not claimed, even when it lies in the window.
- R7: `pci_block` pulses in cycle N+1 for a PCI request in cycle N. It uses the same comparison on PCI address bits 35:20, gated by bit 31, and is suppressed by any bit of `pci_gap_hit`.
- R8: Each accepted request gives a pulse exactly one cycle long. With no request present, both outputs are low.
- R9: The window reaches up to the last byte below 64 GB. Address 0xF_FFFF_FFFF is claimed for any boundary at or below 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Current configuration word |
| host_req_valid | input | 1 | Host memory request present |
| host_addr_hi | input | 16 | Host address bits 35:20 |
| host_gap_hit | input | NUM_GAPS (2) | Gap checker hits for the host request |
| host_claim | output | 1 | Host request claimed for forwarding |
| pci_req_valid | input | 1 | PCI-inbound memory request present |
| pci_addr_hi | input | 16 | PCI address bits 35:20 |
| pci_gap_hit | input | NUM_GAPS (2) | Gap checker hits for the PCI request |
| pci_block | output | 1 | PCI request blocked from the host bus |

## Verification
The assertions check on every cycle that the reserved field stays zero and that no pulse appears without a request one cycle before. They also check that a claim never follows a gap hit or an index below the boundary, that a disabled word silences both outputs, and that an unrequested cycle ends a pulse. Only the bench's scenarios can show the positive side: that a claim really does appear at the exact boundary, for the 1 MB and maximum boundaries, at the top byte below 64 GB, and on the PCI side. A design that never asserts anything would satisfy every assertion.

// File: rtl/tomf_pkg.sv
package tomf_pkg;

   // configuration word layout
   localparam int unsigned CFG_W      = 32;
   localparam int unsigned EN_BIT     = 31;
   localparam int unsigned TOM_W      = 16;

   // address geometry
   localparam int unsigned ADDR_W     = 36;
   localparam int unsigned GRAN_SHIFT = 20;   // 1 MB units
   localparam int unsigned LIMIT_W    = 36;   // 64 GB ceiling

   // bits of the configuration word that hold state
   function automatic logic [CFG_W-1:0] cfg_keep_mask(input int unsigned en_bit,
                                                      input int unsigned tom_w);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < CFG_W; i++) begin
         if (i == en_bit || i < tom_w) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/tomf_cfg_reg.sv
module tomf_cfg_reg #(
   parameter int unsigned CFG_W  = tomf_pkg::CFG_W,
   parameter int unsigned EN_BIT = tomf_pkg::EN_BIT,
   parameter int unsigned TOM_W  = tomf_pkg::TOM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] cfg_q,
   output logic             fwd_en,
   output logic [TOM_W-1:0] tom
);

   localparam logic [CFG_W-1:0] KEEP = tomf_pkg::cfg_keep_mask(EN_BIT, TOM_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q <= wr_data & KEEP;
      end
   end

   assign fwd_en = cfg_q[EN_BIT];
   assign tom    = cfg_q[TOM_W-1:0];

endmodule

// File: rtl/tomf_req_stage.sv
module tomf_req_stage #(
   parameter int unsigned IDX_W    = 16,
   parameter int unsigned NUM_GAPS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [IDX_W-1:0]    req_idx,
   input  logic [NUM_GAPS-1:0] gap_hit,
   output logic                valid_q,
   output logic [IDX_W-1:0]    idx_q,
   output logic                gap_any_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         idx_q     <= '0;
         gap_any_q <= 1'b0;
      end else begin
         valid_q   <= req_valid;
         idx_q     <= req_idx;
         gap_any_q <= |gap_hit;
      end
   end

endmodule

// File: rtl/tomf_range_cmp.sv
module tomf_range_cmp #(
   parameter int unsigned IDX_W      = 16,
   parameter int unsigned TOM_W      = 16,
   parameter int unsigned GRAN_SHIFT = 20,
   parameter int unsigned LIMIT_W    = 36
) (
   input  logic             valid,
   input  logic [IDX_W-1:0] idx,
   input  logic [TOM_W-1:0] tom,
   input  logic             fwd_en,
   input  logic             gap_any,
   output logic             hit
);

   localparam int unsigned LIMIT_IDX_W = LIMIT_W - GRAN_SHIFT;

   logic [IDX_W-1:0] tom_ext;
   logic             below_limit;
   logic             at_or_above;

   generate
      if (IDX_W > TOM_W) begin : g_tom_pad
         assign tom_ext = {{(IDX_W-TOM_W){1'b0}}, tom};
      end else begin : g_tom_same
         assign tom_ext = tom;
      end

      if (IDX_W > LIMIT_IDX_W) begin : g_limit_chk
         assign below_limit = ~|idx[IDX_W-1:LIMIT_IDX_W];
      end else begin : g_limit_free
         assign below_limit = 1'b1;
      end
   endgenerate

   assign at_or_above = (idx >= tom_ext);
   assign hit = valid & fwd_en & at_or_above & below_limit & ~gap_any;

endmodule

// File: rtl/tom_fwd_decoder.sv
module tom_fwd_decoder #(
   parameter int unsigned CFG_W      = tomf_pkg::CFG_W,
   parameter int unsigned EN_BIT     = tomf_pkg::EN_BIT,
   parameter int unsigned TOM_W      = tomf_pkg::TOM_W,
   parameter int unsigned ADDR_W     = tomf_pkg::ADDR_W,
   parameter int unsigned GRAN_SHIFT = tomf_pkg::GRAN_SHIFT,
   parameter int unsigned LIMIT_W    = tomf_pkg::LIMIT_W,
   parameter int unsigned NUM_GAPS   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_wr_en,
   input  logic [CFG_W-1:0]             cfg_wr_data,
   output logic [CFG_W-1:0]             cfg_rd_data,
   input  logic                         host_req_valid,
   input  logic [ADDR_W-1:GRAN_SHIFT]   host_addr_hi,
   input  logic [NUM_GAPS-1:0]          host_gap_hit,
   output logic                         host_claim,
   input  logic                         pci_req_valid,
   input  logic [ADDR_W-1:GRAN_SHIFT]   pci_addr_hi,
   input  logic [NUM_GAPS-1:0]          pci_gap_hit,
   output logic                         pci_block
);

   localparam int unsigned IDX_W   = ADDR_W - GRAN_SHIFT;
   localparam int unsigned N_SIDES = 2;   // 0: host outbound, 1: PCI inbound

   // elaboration-time parameter checks
   generate
      if (IDX_W < TOM_W) begin : g_bad_idx
         $error("address index narrower than boundary field");
      end
      if (EN_BIT < TOM_W || EN_BIT >= CFG_W) begin : g_bad_en
         $error("enable bit overlaps boundary or lies outside word");
      end
      if (NUM_GAPS < 1) begin : g_bad_gaps
         $error("at least one gap input required");
      end
      if (LIMIT_W <= GRAN_SHIFT) begin : g_bad_limit
         $error("ceiling must lie above the granule");
      end
   endgenerate

   logic             fwd_en;
   logic [TOM_W-1:0] tom;

   tomf_cfg_reg #(
      .CFG_W  (CFG_W),
      .EN_BIT (EN_BIT),
      .TOM_W  (TOM_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .cfg_q   (cfg_rd_data),
      .fwd_en  (fwd_en),
      .tom     (tom)
   );

   logic [N_SIDES-1:0]  side_valid;
   logic [IDX_W-1:0]    side_idx  [N_SIDES];
   logic [NUM_GAPS-1:0] side_gap  [N_SIDES];
   logic [N_SIDES-1:0]  side_hit;

   assign side_valid[0] = host_req_valid;
   assign side_valid[1] = pci_req_valid;
   assign side_idx[0]   = host_addr_hi;
   assign side_idx[1]   = pci_addr_hi;
   assign side_gap[0]   = host_gap_hit;
   assign side_gap[1]   = pci_gap_hit;

   generate
      for (genvar s = 0; s < N_SIDES; s++) begin : g_side
         logic             valid_q;
         logic [IDX_W-1:0] idx_q;
         logic             gap_any_q;

         tomf_req_stage #(
            .IDX_W    (IDX_W),
            .NUM_GAPS (NUM_GAPS)
         ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (side_valid[s]),
            .req_idx   (side_idx[s]),
            .gap_hit   (side_gap[s]),
            .valid_q   (valid_q),
            .idx_q     (idx_q),
            .gap_any_q (gap_any_q)
         );

         tomf_range_cmp #(
            .IDX_W      (IDX_W),
            .TOM_W      (TOM_W),
            .GRAN_SHIFT (GRAN_SHIFT),
            .LIMIT_W    (LIMIT_W)
         ) u_cmp (
            .valid   (valid_q),
            .idx     (idx_q),
            .tom     (tom),
            .fwd_en  (fwd_en),
            .gap_any (gap_any_q),
            .hit     (side_hit[s])
         );
      end
   endgenerate

   assign host_claim = side_hit[0];
   assign pci_block  = side_hit[1];

endmodule

// File: rtl/tomf_chk.sv
module tomf_chk #(
   parameter int unsigned CFG_W    = 32,
   parameter int unsigned EN_BIT   = 31,
   parameter int unsigned TOM_W    = 16,
   parameter int unsigned IDX_W    = 16,
   parameter int unsigned NUM_GAPS = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [CFG_W-1:0]    cfg_rd_data,
   input logic                host_req_valid,
   input logic [IDX_W-1:0]    host_addr_hi,
   input logic [NUM_GAPS-1:0] host_gap_hit,
   input logic                host_claim,
   input logic                pci_req_valid,
   input logic [NUM_GAPS-1:0] pci_gap_hit,
   input logic                pci_block
);

   // R2
   cfg_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_data[EN_BIT-1:TOM_W] == '0);

   // R3
   claim_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_claim |-> $past(host_req_valid));

   // R4
   claim_above_tom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_claim |-> ($past(host_addr_hi) >= IDX_W'(cfg_rd_data[TOM_W-1:0])));

   // R5
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd_data[EN_BIT] |-> (!host_claim && !pci_block));

   // R6
   claim_gap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_claim |-> !$past(|host_gap_hit));

   // R7
   block_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pci_block |-> ($past(pci_req_valid) && !$past(|pci_gap_hit)));

   // R8
   claim_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_claim && !host_req_valid) |=> !host_claim);

   // R8
   block_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_block && !pci_req_valid) |=> !pci_block);

endmodule

bind tom_fwd_decoder tomf_chk #(
   .CFG_W    (CFG_W),
   .EN_BIT   (EN_BIT),
   .TOM_W    (TOM_W),
   .IDX_W    (ADDR_W - GRAN_SHIFT),
   .NUM_GAPS (NUM_GAPS)
) u_tomf_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_rd_data    (cfg_rd_data),
   .host_req_valid (host_req_valid),
   .host_addr_hi   (host_addr_hi),
   .host_gap_hit   (host_gap_hit),
   .host_claim     (host_claim),
   .pci_req_valid  (pci_req_valid),
   .pci_gap_hit    (pci_gap_hit),
   .pci_block      (pci_block)
);

// File: tb/tom_fwd_decoder_tb.sv
module tom_fwd_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_VEC      = 11;
   localparam int VEC_W      = 32 + 36 + 2 + 1 + 4;

   // {cfg word, address, gap hits, expected claim, requirement number}
   localparam logic [VEC_W-1:0] VECS [N_VEC] = '{
      {32'h8000_0100, 36'h0_1000_0000, 2'b00, 1'b1, 4'd4},  // R4 exactly at boundary
      {32'h8000_0100, 36'h0_0FFF_FFFF, 2'b00, 1'b0, 4'd4},  // R4 one below
      {32'h8000_0100, 36'hF_FFFF_FFFF, 2'b00, 1'b1, 4'd9},  // R9 last byte below 64 GB
      {32'h8000_0100, 36'h2_0000_0000, 2'b01, 1'b0, 4'd6},  // R6 gap 0
      {32'h8000_0100, 36'h2_0000_0000, 2'b10, 1'b0, 4'd6},  // R6 gap 1
      {32'h0000_0100, 36'h2_0000_0000, 2'b00, 1'b0, 4'd5},  // R5 disabled
      {32'h8000_0001, 36'h0_0010_0000, 2'b00, 1'b1, 4'd4},  // R4 1 MB boundary
      {32'h8000_0001, 36'h0_000F_FFFF, 2'b00, 1'b0, 4'd4},  // R4 below 1 MB
      {32'h8000_FFFF, 36'hF_FFF0_0000, 2'b00, 1'b1, 4'd9},  // R9 top boundary
      {32'h8000_FFFF, 36'hF_FFEF_FFFF, 2'b00, 1'b0, 4'd4},  // R4 below top boundary
      {32'h8000_0000, 36'h0_0000_0000, 2'b00, 1'b1, 4'd3}   // R3 zero boundary
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic [31:0] cfg_rd_data;
   logic        host_req_valid = 1'b0;
   logic [35:20] host_addr_hi = '0;
   logic [1:0]  host_gap_hit = '0;
   logic        host_claim;
   logic        pci_req_valid = 1'b0;
   logic [35:20] pci_addr_hi = '0;
   logic [1:0]  pci_gap_hit = '0;
   logic        pci_block;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tom_fwd_decoder dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_wr_en      (cfg_wr_en),
      .cfg_wr_data    (cfg_wr_data),
      .cfg_rd_data    (cfg_rd_data),
      .host_req_valid (host_req_valid),
      .host_addr_hi   (host_addr_hi),
      .host_gap_hit   (host_gap_hit),
      .host_claim     (host_claim),
      .pci_req_valid  (pci_req_valid),
      .pci_addr_hi    (pci_addr_hi),
      .pci_gap_hit    (pci_gap_hit),
      .pci_block      (pci_block)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [31:0] d);
      cfg_wr_en   = 1'b1;
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
   endtask

   // request in cycle N, pulse checked in N+1, gone in N+2
   task automatic host_req(input logic [35:0] a, input logic [1:0] g,
                           input logic exp, input string tag);
      host_req_valid = 1'b1;
      host_addr_hi   = a[35:20];
      host_gap_hit   = g;
      @(negedge clk);
      host_req_valid = 1'b0;
      host_gap_hit   = '0;
      check(tag, 64'(host_claim), 64'(exp));
      @(negedge clk);
      check("R8 claim pulse ends", 64'(host_claim), 64'd0);
   endtask

   task automatic pci_req(input logic [35:0] a, input logic [1:0] g,
                          input logic exp, input string tag);
      pci_req_valid = 1'b1;
      pci_addr_hi   = a[35:20];
      pci_gap_hit   = g;
      @(negedge clk);
      pci_req_valid = 1'b0;
      pci_gap_hit   = '0;
      check(tag, 64'(pci_block), 64'(exp));
      @(negedge clk);
      check("R8 block pulse ends", 64'(pci_block), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 cfg after reset", 64'(cfg_rd_data), 64'd0);
      check("R1 claim after reset", 64'(host_claim), 64'd0);
      check("R1 block after reset", 64'(pci_block), 64'd0);

      // R2 reserved bits dropped
      write_cfg(32'hFFFF_FFFF);
      check("R2 readback", 64'(cfg_rd_data), 64'h8000_FFFF);
      write_cfg(32'h7FFF_0000);
      check("R2 reserved only", 64'(cfg_rd_data), 64'h0);

      // vector table
      for (int i = 0; i < N_VEC; i++) begin
         logic [VEC_W-1:0] v;
         string tag;
         v = VECS[i];
         tag = $sformatf("R%0d vector %0d", v[3:0], i);
         write_cfg(v[74:43]);
         host_req(v[42:7], v[6:5], v[4], tag);
      end

      // R7 PCI-inbound blocking
      write_cfg(32'h8000_0100);
      pci_req(36'h0_1000_0000, 2'b00, 1'b1, "R7 pci at boundary");
      pci_req(36'h0_0FFF_FFFF, 2'b00, 1'b0, "R7 pci below boundary");
      pci_req(36'h3_0000_0000, 2'b01, 1'b0, "R7 pci in gap");
      pci_req(36'hF_FFFF_FFFF, 2'b00, 1'b1, "R7 pci top byte");
      write_cfg(32'h0000_0100);
      pci_req(36'h3_0000_0000, 2'b00, 1'b0, "R5 pci disabled");

      // R8 idle: no request, no pulse
      write_cfg(32'h8000_0000);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R8 idle claim", 64'(host_claim), 64'd0);
         check("R8 idle block", 64'(pci_block), 64'd0);
      end

      // R3 back-to-back requests give one pulse each
      host_req_valid = 1'b1;
      host_addr_hi   = 16'h0400;
      @(negedge clk);
      check("R3 first of pair", 64'(host_claim), 64'd1);
      host_addr_hi   = 16'h0800;
      @(negedge clk);
      host_req_valid = 1'b0;
      check("R3 second of pair", 64'(host_claim), 64'd1);
      @(negedge clk);
      check("R8 pair ends", 64'(host_claim), 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule